// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns 16-bit segment bases and 16-bit offsets into 20-bit physical byte addresses. It holds four segment base registers: code, data, stack and extra. It also holds a 16-bit instruction pointer.

Each request names an access kind and an offset. The block picks the segment base for that kind and shifts the base left by four bit positions. It then adds the offset and presents the truncated 20-bit sum one clock later.

Instruction fetches ignore the supplied offset and use the instruction pointer instead. The execution side steps the pointer forward as it accepts instructions, or loads it directly for a jump. Software-visible segment bases are written through a separate write port. A segment override lets a data access borrow any of the four bases.

Top module: `seg_addr_gen`

## Requirements
- R1: During and after a synchronous active-high reset, `addr_valid` is 0 and `ip_out` is 0. The code base resets to 16'hFFFF and the other three bases reset to 0, so the first fetch after reset with no writes yields 20'hFFFF0.
- R2: For a request, `addr_out` equals (base << 4) + offset, truncated to 20 bits. It appears on the clock edge that follows the cycle in which `req_valid` is high.
- R3: `req_kind` selects the base as follows: 0 uses code (fetch), 1 uses data, 2 uses stack and 3 uses extra. `seg_wr_sel` uses the same numbering: 0 is code, 1 is data, 2 is stack and 3 is extra.
- R4: A fetch (`req_kind` = 0) uses the instruction pointer value from the request cycle as the offset, and `req_offset` has no effect on the result.
- R5: When `req_ovr_en` is 1 on a data request (`req_kind` = 1), the base numbered `req_ovr_seg` (same numbering as R3) is used. The override has no effect on fetch, stack or extra requests.
- R6: A segment write takes effect for requests in later cycles only. A request in the same cycle as the write uses the old base.
- R7: With `ip_advance` high and `ip_load` low, the pointer grows by `ip_adv_len` on the next edge, wrapping modulo 2^16. With neither input high, the pointer holds its value.
- R8: With `ip_load` high, the pointer takes `ip_load_val` on the next edge, whether or not `ip_advance` is high.
- R9: A sum beyond 20 bits wraps modulo 2^20. For example, base 16'hFFFF with offset 16'hFFFF gives 20'h0FFEF.
- R10: `addr_valid` equals `req_valid` delayed by one cycle. When no request was made, `addr_out` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 extra |
| req_offset | input | 16 | Offset for non-fetch requests |
| req_ovr_en | input | 1 | Enable segment override on a data request |
| req_ovr_seg | input | 2 | Base used when the override applies |
| seg_wr_en | input | 1 | Segment base write strobe |
| seg_wr_sel | input | 2 | Base to write: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | New base value |
| ip_advance | input | 1 | An instruction was accepted; step the pointer |
| ip_adv_len | input | 3 | Byte length to step by |
| ip_load | input | 1 | Jump: load the pointer |
| ip_load_val | input | 16 | Jump target |
| addr_valid | output | 1 | `addr_out` carries a fresh result |
| addr_out | output | 20 | Physical address |
| ip_out | output | 16 | Current instruction pointer |

## Verification
The assertions check the timing contract on every cycle. `addr_valid` must track `req_valid` one cycle late, and `addr_out` must hold when there was no request. The pointer must step, load with priority, or hold exactly as R7 and R8 require.

Some behaviours only the scenarios can show, because they depend on stored base values and on how the inputs are combined. These are the choice of segment for each access kind, the override rules, fetch offset substitution, old-value use on a same-cycle write, and the 1 MB wrap. A scoreboard model predicts each of these results.

// File: rtl/sag_pkg.sv
package sag_pkg;

    parameter int SEG_W     = 16;
    parameter int OFF_W     = 16;
    parameter int SEG_SHIFT = 4;
    parameter int PA_W      = SEG_W + SEG_SHIFT;
    parameter int NUM_SEG   = 4;
    parameter int SEL_W     = $clog2(NUM_SEG);
    parameter logic [SEG_W-1:0] CODE_BASE_RST  = 16'hFFFF;
    parameter logic [SEG_W-1:0] OTHER_BASE_RST = 16'h0000;

    typedef enum logic [SEL_W-1:0] {
        KIND_FETCH = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_STACK = 2'd2,
        KIND_EXTRA = 2'd3
    } acc_kind_e;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_sel_e;

    typedef struct packed {
        logic             valid;
        acc_kind_e        kind;
        logic [OFF_W-1:0] offset;
        logic             ovr_en;
        seg_sel_e         ovr_seg;
    } addr_req_t;

    typedef struct packed {
        logic            en;
        seg_sel_e        sel;
        logic [SEG_W-1:0] data;
    } seg_wr_t;

    // Default base for each access kind
    function automatic seg_sel_e default_seg(input acc_kind_e kind);
        seg_sel_e s;
        case (kind)
            KIND_FETCH: s = SEG_CODE;
            KIND_DATA:  s = SEG_DATA;
            KIND_STACK: s = SEG_STACK;
            default:    s = SEG_EXTRA;
        endcase
        return s;
    endfunction

    // Only data accesses honour an override
    function automatic seg_sel_e resolve_seg(input addr_req_t r);
        seg_sel_e s;
        if (r.kind == KIND_DATA && r.ovr_en) s = r.ovr_seg;
        else                                 s = default_seg(r.kind);
        return s;
    endfunction

    function automatic logic [SEG_W-1:0] seg_reset_value(input int idx);
        return (idx == int'(SEG_CODE)) ? CODE_BASE_RST : OTHER_BASE_RST;
    endfunction

    // Shift-and-add, truncated to the physical width
    function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
        logic [PA_W-1:0] shifted;
        logic [PA_W-1:0] widened;
        shifted = {base, {SEG_SHIFT{1'b0}}};
        widened = PA_W'(off);
        return shifted + widened;
    endfunction

endpackage

// File: rtl/sag_seg_regs.sv
module sag_seg_regs
    import sag_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  seg_wr_t                         wr,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   bases
);

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
        localparam logic [SEG_W-1:0] RST_VAL = seg_reset_value(g);
        logic hit;
        assign hit = wr.en && (int'(wr.sel) == g);

        always_ff @(posedge clk) begin
            if (rst)      bases[g] <= RST_VAL;
            else if (hit) bases[g] <= wr.data;
        end
    end

endmodule

// File: rtl/sag_ip_unit.sv
module sag_ip_unit
    import sag_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic              load,
    input  logic [OFF_W-1:0]  load_val,
    output logic [OFF_W-1:0]  ip
);

    logic [OFF_W-1:0] ip_next;

    always_comb begin
        ip_next = ip;
        if (load)         ip_next = load_val;
        else if (advance) ip_next = ip + OFF_W'(adv_len);
    end

    always_ff @(posedge clk) begin
        if (rst) ip <= '0;
        else     ip <= ip_next;
    end

endmodule

// File: rtl/sag_addr_stage.sv
module sag_addr_stage
    import sag_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  addr_req_t                      req,
    input  logic [OFF_W-1:0]               ip,
    input  logic [NUM_SEG-1:0][SEG_W-1:0]  bases,
    output logic                           valid_q,
    output logic [PA_W-1:0]                addr_q
);

    seg_sel_e          sel;
    logic [SEG_W-1:0]  base;
    logic [OFF_W-1:0]  off;
    logic [PA_W-1:0]   sum;

    always_comb begin
        sel  = resolve_seg(req);
        base = bases[sel];
        off  = (req.kind == KIND_FETCH) ? ip : req.offset;
        sum  = phys_addr(base, off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= req.valid;
            if (req.valid) addr_q <= sum;
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import sag_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_kind,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_ovr_en,
    input  logic [SEL_W-1:0]  req_ovr_seg,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              ip_advance,
    input  logic [LEN_W-1:0]  ip_adv_len,
    input  logic              ip_load,
    input  logic [OFF_W-1:0]  ip_load_val,
    output logic              addr_valid,
    output logic [PA_W-1:0]   addr_out,
    output logic [OFF_W-1:0]  ip_out
);

    addr_req_t                     req;
    seg_wr_t                       wr;
    logic [NUM_SEG-1:0][SEG_W-1:0] bases;

    always_comb begin
        req.valid   = req_valid;
        req.kind    = acc_kind_e'(req_kind);
        req.offset  = req_offset;
        req.ovr_en  = req_ovr_en;
        req.ovr_seg = seg_sel_e'(req_ovr_seg);
        wr.en       = seg_wr_en;
        wr.sel      = seg_sel_e'(seg_wr_sel);
        wr.data     = seg_wr_data;
    end

    sag_seg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .bases (bases)
    );

    sag_ip_unit #(.LEN_W(LEN_W)) u_ip (
        .clk      (clk),
        .rst      (rst),
        .advance  (ip_advance),
        .adv_len  (ip_adv_len),
        .load     (ip_load),
        .load_val (ip_load_val),
        .ip       (ip_out)
    );

    sag_addr_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ip      (ip_out),
        .bases   (bases),
        .valid_q (addr_valid),
        .addr_q  (addr_out)
    );

endmodule

// File: rtl/sag_checker.sv
module sag_checker
    import sag_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              ip_advance,
    input logic [LEN_W-1:0]  ip_adv_len,
    input logic              ip_load,
    input logic [OFF_W-1:0]  ip_load_val,
    input logic              addr_valid,
    input logic [PA_W-1:0]   addr_out,
    input logic [OFF_W-1:0]  ip_out
);

    p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid);

    p_idle_lat_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(addr_out));

    p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ip_load |=> ip_out == $past(ip_load_val));

    p_ip_step_r7: assert property (@(posedge clk) disable iff (rst)
        (ip_advance && !ip_load) |=>
            ip_out == OFF_W'($past(ip_out) + OFF_W'($past(ip_adv_len))));

    p_ip_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ip_advance && !ip_load) |=> $stable(ip_out));

endmodule

bind seg_addr_gen sag_checker #(.LEN_W(LEN_W)) u_sag_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .ip_advance  (ip_advance),
    .ip_adv_len  (ip_adv_len),
    .ip_load     (ip_load),
    .ip_load_val (ip_load_val),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out),
    .ip_out      (ip_out)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [15:0] req_offset;
    logic        req_ovr_en;
    logic [1:0]  req_ovr_seg;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        ip_advance;
    logic [2:0]  ip_adv_len;
    logic        ip_load;
    logic [15:0] ip_load_val;
    logic        addr_valid;
    logic [19:0] addr_out;
    logic [15:0] ip_out;

    always #5 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .ip_advance(ip_advance), .ip_adv_len(ip_adv_len),
        .ip_load(ip_load), .ip_load_val(ip_load_val),
        .addr_valid(addr_valid), .addr_out(addr_out), .ip_out(ip_out)
    );

    typedef struct {
        int          cyc;
        logic        v;
        logic [19:0] a;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cyc      = 0;
    logic [15:0] m_seg [4];
    logic [15:0] m_ip;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each registered result against the scoreboard
    always @(negedge clk) begin
        if (!rst && sb.size() > 0 && sb[0].cyc < cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(addr_valid == e.v, e.tag, "addr_valid", 32'(addr_valid), 32'(e.v));
            if (e.v)
                check(addr_out == e.a, e.tag, "addr_out", 32'(addr_out), 32'(e.a));
        end
    end

    // Driver: one cycle of stimulus plus the expected result
    task automatic step(input bit rv, input logic [1:0] k, input logic [15:0] off,
                        input bit oe, input logic [1:0] os,
                        input bit we, input logic [1:0] ws, input logic [15:0] wd,
                        input bit adv, input logic [2:0] len,
                        input bit ld, input logic [15:0] lv, input string tag);
        exp_t        e;
        logic [1:0]  sel;
        logic [15:0] eoff;
        @(negedge clk);
        check(ip_out == m_ip, tag, "ip_out", 32'(ip_out), 32'(m_ip));
        req_valid = rv;  req_kind = k;  req_offset = off;
        req_ovr_en = oe; req_ovr_seg = os;
        seg_wr_en = we;  seg_wr_sel = ws; seg_wr_data = wd;
        ip_advance = adv; ip_adv_len = len; ip_load = ld; ip_load_val = lv;
        sel  = (k == 2'd1 && oe) ? os : k;
        eoff = (k == 2'd0) ? m_ip : off;
        e.cyc = cyc;
        e.v   = rv;
        e.a   = 20'({m_seg[sel], 4'h0} + {4'h0, eoff});
        e.tag = tag;
        sb.push_back(e);
        if (we) m_seg[ws] = wd;
        if (ld)       m_ip = lv;
        else if (adv) m_ip = m_ip + 16'(len);
    endtask

    task automatic req(input logic [1:0] k, input logic [15:0] off, input string tag);
        step(1, k, off, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wseg(input logic [1:0] s, input logic [15:0] d);
        step(0, 0, 0, 0, 0, 1, s, d, 0, 0, 0, 0, "R6");
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_kind = 0; req_offset = 0; req_ovr_en = 0; req_ovr_seg = 0;
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        ip_advance = 0; ip_adv_len = 0; ip_load = 0; ip_load_val = 0;
        m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(addr_valid == 0, "R1", "addr_valid in reset", 32'(addr_valid), 0);
        check(ip_out == 0, "R1", "ip_out in reset", 32'(ip_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(addr_valid == 0, "R1", "addr_valid after reset", 32'(addr_valid), 0);

        // R1: first fetch from the reset code base -> FFFF0
        req(0, 16'h1234, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");

        // Load bases, then each kind picks its own base (R2, R3)
        wseg(1, 16'h1234);
        wseg(2, 16'h2000);
        wseg(3, 16'hABCD);
        wseg(0, 16'h0100);
        req(1, 16'h0010, "R3");
        req(2, 16'hFFFE, "R3");
        req(3, 16'h0001, "R2");
        req(0, 16'hBEEF, "R4");

        // R4/R7: fetch and advance in one cycle uses the old pointer
        step(1, 0, 16'h5555, 0, 0, 0, 0, 0, 1, 3'd3, 0, 0, "R4");
        req(0, 16'h0000, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");

        // R7 wrap of the pointer
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 0, 0, "R7");
        req(0, 16'h0000, "R7");

        // R8: load beats advance
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd5, 1, 16'h4000, "R8");
        req(0, 16'h0000, "R8");

        // R5: override on data; ignored on fetch, stack, extra
        step(1, 1, 16'h0020, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 16'h0020, 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 2, 16'h0020, 1, 2'd1, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 3, 16'h0020, 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 16'h0020, 1, 2'd3, 0, 0, 0, 0, 0, 0, 0, "R5");

        // R6: write and request in the same cycle
        step(1, 1, 16'h0004, 0, 0, 1, 2'd1, 16'h5000, 0, 0, 0, 0, "R6");
        req(1, 16'h0004, "R6");

        // R9: 1 MB wrap
        wseg(3, 16'hFFFF);
        req(3, 16'hFFFF, "R9");
        req(3, 16'h0010, "R9");

        // R10: idle cycles hold the last address and drop valid
        step(0, 2, 16'h7777, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        check(addr_out == 20'h00000, "R10", "held addr_out", 32'(addr_out), 32'h0);
        @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R10", "scoreboard drained", 32'(sb.size()), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule